// File: doc/BRIEF.md
# Bus-Master Burst Mover with Request/Grant Handshake

This block moves words between the device's internal buffers and a shared external data bus without the host having to poll. Whenever the outbound buffer (filled by the serial side, emptied onto the bus) holds words, or the inbound buffer (filled from the bus) has room and inbound moves are allowed, the engine raises a bus request. Once the external arbiter grants the bus, it issues one data strobe per clock until the burst is complete, and then gives the bus back.

The engine never drives an address. A latch/counter outside the block supplies the memory addresses. The engine gives that counter a one-cycle start pulse at the first word of every new burst and lets each strobe advance it. If the arbiter takes the grant away part way through, the engine pauses on a word boundary, keeps requesting and finishes the rest of the burst without sending another start pulse. The burst length is fixed when the request is raised.

Top module: `dma_bus_master`

## Requirements
- R1: While reset is held and right after it, `bus_req`, `bus_wr_stb`, `bus_rd_stb`, `bus_doe`, `addr_start`, `rx_pop` and `tx_push` are all 0.
- R2: When the engine is idle and `rx_level` is non-zero at a rising edge, `bus_req` is 1 from that edge onward. It is never raised while nothing is pending.
- R3: A data strobe (`bus_wr_stb` or `bus_rd_stb`) is 1 only in a cycle where both `bus_gnt` and `bus_req` are 1.
- R4: The number of strobes in one request period equals min(selected level, limit). The limit is `cfg_burst_max`, and a value of 0 selects the default of 16. Both inputs are sampled at the edge where the request is raised.
- R5: When `rx_level` is non-zero and inbound moves are also pending, the burst moves outbound data: `bus_wr_stb` strobes and `bus_dir`=1.
- R6: An inbound burst (`bus_rd_stb`, `bus_dir`=0) starts only if `tx_enable` is 1 and `tx_space` is non-zero. Every `bus_rd_stb` cycle also asserts `tx_push`, with `tx_wdata` equal to `bus_din`.
- R7: `bus_req` falls at the clock edge right after the last strobe of a burst. `bus_doe` is 1 only while `bus_gnt` is 1. After an outbound burst it stays 1 for as long as the grant is kept.
- R8: If `bus_gnt` drops mid-burst, strobes stop at once and `bus_req` stays 1. The burst resumes on a new grant and delivers exactly the words that remain.
- R9: `addr_start` is 1 together with the first strobe of every new burst, and 0 in every other cycle, including the cycles where a paused burst resumes.
- R10: During outbound strobes `bus_dout` carries `rx_data`, `rx_pop` is 1 and `bus_doe` is 1, so the words leave in buffer order. The two strobes are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_burst_max | input | LVL_W | Burst limit in words, 0 selects the default |
| rx_level | input | LVL_W | Words held in the outbound buffer |
| rx_data | input | DATA_W | Head word of the outbound buffer |
| rx_pop | output | 1 | Consume the head word of the outbound buffer |
| tx_space | input | LVL_W | Free words in the inbound buffer |
| tx_enable | input | 1 | Allow inbound bursts |
| tx_push | output | 1 | Write one word into the inbound buffer |
| tx_wdata | output | DATA_W | Word written into the inbound buffer |
| bus_req | output | 1 | Bus request to the external arbiter |
| bus_gnt | input | 1 | Bus grant from the external arbiter |
| bus_dir | output | 1 | 1 = buffer to bus, 0 = bus to buffer |
| addr_start | output | 1 | Reloads the external address counter |
| bus_wr_stb | output | 1 | Write strobe, engine drives data |
| bus_rd_stb | output | 1 | Read strobe, memory drives data |
| bus_dout | output | DATA_W | Data driven onto the bus |
| bus_doe | output | 1 | Output enable for bus_dout |
| bus_din | input | DATA_W | Data read from the bus |

## Verification
The hardest case to reach is a grant that is withdrawn in the middle of a burst and returned later. The engine must then carry on with the same remaining count and no fresh start pulse, while the level inputs keep changing underneath it. The bench drives a random arbiter that grants a pending request after a random delay and pulls the grant back at random while words are still owed. A background producer and a background drainer move the buffer levels during these pauses. Directed runs cover the default limit, the priority of outbound over inbound moves, and an inbound move that is inhibited.

// File: rtl/dma_pkg.sv
package dma_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_XFER = 2'd2,
      ST_HOLD = 2'd3
   } dma_state_e;

   typedef enum logic {
      DIR_FROM_BUS = 1'b0,
      DIR_TO_BUS   = 1'b1
   } dma_dir_e;
endpackage

// File: rtl/dma_burst_sizer.sv
module dma_burst_sizer
   import dma_pkg::*;
#(
   parameter int LVL_W       = 8,
   parameter int DEF_BURST   = 16,
   parameter bit USE_CFG_MAX = 1'b1
) (
   input  logic [LVL_W-1:0] rx_level,
   input  logic [LVL_W-1:0] tx_space,
   input  logic             tx_enable,
   input  logic [LVL_W-1:0] cfg_burst_max,
   output logic             pending,
   output dma_dir_e         dir,
   output logic [LVL_W-1:0] len
);
   localparam logic [LVL_W-1:0] DEF_L = LVL_W'(DEF_BURST);

   logic [LVL_W-1:0] limit;
   logic [LVL_W-1:0] src;
   logic             rx_ready;
   logic             tx_ready;

   generate
      if (USE_CFG_MAX) begin : g_cfg_limit
         assign limit = (cfg_burst_max == '0) ? DEF_L : cfg_burst_max;
      end else begin : g_fixed_limit
         logic unused_cfg;
         assign unused_cfg = ^cfg_burst_max;
         assign limit      = DEF_L;
      end
   endgenerate

   assign rx_ready = (rx_level != '0);
   assign tx_ready = tx_enable && (tx_space != '0);
   assign pending  = rx_ready || tx_ready;
   assign dir      = rx_ready ? DIR_TO_BUS : DIR_FROM_BUS;
   assign src      = rx_ready ? rx_level : tx_space;
   assign len      = (src < limit) ? src : limit;
endmodule

// File: rtl/dma_word_counter.sv
module dma_word_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             dec,
   output logic             last
);
   logic [CNT_W-1:0] remain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remain <= '0;
      end else if (load) begin
         remain <= load_val;
      end else if (dec) begin
         remain <= remain - 1'b1;
      end
   end

   assign last = (remain == CNT_W'(1));
endmodule

// File: rtl/dma_bus_fsm.sv
module dma_bus_fsm
   import dma_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pending,
   input  logic       gnt,
   input  logic       last,
   output dma_state_e state,
   output logic       start,
   output logic       word,
   output logic       req,
   output logic       first
);
   dma_state_e nxt;
   logic       fresh;

   always_comb begin
      nxt   = state;
      start = 1'b0;
      unique case (state)
         ST_IDLE: if (pending) begin
            nxt   = ST_REQ;
            start = 1'b1;
         end
         ST_REQ:  if (gnt) nxt = ST_XFER;
         ST_XFER: begin
            if (!gnt)      nxt = ST_REQ;
            else if (last) nxt = ST_HOLD;
         end
         ST_HOLD: if (!gnt) nxt = ST_IDLE;
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         fresh <= 1'b0;
      end else begin
         state <= nxt;
         if (start)     fresh <= 1'b1;
         else if (word) fresh <= 1'b0;
      end
   end

   assign word  = (state == ST_XFER) && gnt;
   assign req   = (state == ST_REQ) || (state == ST_XFER);
   assign first = word && fresh;
endmodule

// File: rtl/dma_bus_master.sv
module dma_bus_master
   import dma_pkg::*;
#(
   parameter int DATA_W        = 32,
   parameter int LVL_W         = 8,
   parameter int DEF_BURST     = 16,
   parameter bit USE_CFG_MAX   = 1'b1,
   parameter bit PARK_DATA_LOW = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LVL_W-1:0]  cfg_burst_max,
   input  logic [LVL_W-1:0]  rx_level,
   input  logic [DATA_W-1:0] rx_data,
   output logic              rx_pop,
   input  logic [LVL_W-1:0]  tx_space,
   input  logic              tx_enable,
   output logic              tx_push,
   output logic [DATA_W-1:0] tx_wdata,
   output logic              bus_req,
   input  logic              bus_gnt,
   output logic              bus_dir,
   output logic              addr_start,
   output logic              bus_wr_stb,
   output logic              bus_rd_stb,
   output logic [DATA_W-1:0] bus_dout,
   output logic              bus_doe,
   input  logic [DATA_W-1:0] bus_din
);
   localparam int MAX_LVL = (1 << LVL_W) - 1;

   generate
      if (DATA_W < 1) begin : g_bad_data_w
         $error("DATA_W must be at least 1");
      end
      if (LVL_W < 2 || LVL_W > 16) begin : g_bad_lvl_w
         $error("LVL_W must lie in 2..16");
      end
      if (DEF_BURST < 1 || DEF_BURST > MAX_LVL) begin : g_bad_def
         $error("DEF_BURST must fit in LVL_W bits and be non-zero");
      end
   endgenerate

   logic             pending;
   dma_dir_e         dir_sel;
   dma_dir_e         dir_q;
   logic [LVL_W-1:0] len_sel;
   dma_state_e       state;
   logic             start;
   logic             word;
   logic             first;
   logic             last;
   logic             to_bus;

   dma_burst_sizer #(
      .LVL_W      (LVL_W),
      .DEF_BURST  (DEF_BURST),
      .USE_CFG_MAX(USE_CFG_MAX)
   ) u_sizer (
      .rx_level     (rx_level),
      .tx_space     (tx_space),
      .tx_enable    (tx_enable),
      .cfg_burst_max(cfg_burst_max),
      .pending      (pending),
      .dir          (dir_sel),
      .len          (len_sel)
   );

   dma_bus_fsm u_fsm (
      .clk    (clk),
      .rst_n  (rst_n),
      .pending(pending),
      .gnt    (bus_gnt),
      .last   (last),
      .state  (state),
      .start  (start),
      .word   (word),
      .req    (bus_req),
      .first  (first)
   );

   dma_word_counter #(
      .CNT_W(LVL_W)
   ) u_count (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (start),
      .load_val(len_sel),
      .dec     (word),
      .last    (last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     dir_q <= DIR_FROM_BUS;
      else if (start) dir_q <= dir_sel;
   end

   assign to_bus     = (dir_q == DIR_TO_BUS);
   assign bus_dir    = to_bus;
   assign bus_wr_stb = word && to_bus;
   assign bus_rd_stb = word && !to_bus;
   assign rx_pop     = bus_wr_stb;
   assign tx_push    = bus_rd_stb;
   assign tx_wdata   = bus_din;
   assign addr_start = first;
   assign bus_doe    = to_bus && bus_gnt &&
                       ((state == ST_XFER) || (state == ST_HOLD));

   generate
      if (PARK_DATA_LOW) begin : g_park_low
         assign bus_dout = bus_doe ? rx_data : '0;
      end else begin : g_pass_through
         assign bus_dout = rx_data;
      end
   endgenerate
endmodule

// File: rtl/dma_bus_master_chk.sv
module dma_bus_master_chk #(
   parameter int LVL_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [LVL_W-1:0] rx_level,
   input logic [LVL_W-1:0] tx_space,
   input logic             bus_req,
   input logic             bus_gnt,
   input logic             bus_wr_stb,
   input logic             bus_rd_stb,
   input logic             bus_doe,
   input logic             addr_start
);
   a_r3_strobe_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr_stb || bus_rd_stb) |-> bus_gnt);

   a_r3_strobe_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr_stb || bus_rd_stb) |-> bus_req);

   a_r10_single_direction: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr_stb && bus_rd_stb));

   a_r7_release_follows_last: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_req) |-> $past(bus_wr_stb || bus_rd_stb));

   a_r7_drive_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
      bus_doe |-> bus_gnt);

   a_r10_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr_stb |-> (rx_level != '0));

   a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd_stb |-> (tx_space != '0));

   a_r9_start_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      addr_start |-> (bus_wr_stb || bus_rd_stb));
endmodule

bind dma_bus_master dma_bus_master_chk #(.LVL_W(LVL_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rx_level  (rx_level),
   .tx_space  (tx_space),
   .bus_req   (bus_req),
   .bus_gnt   (bus_gnt),
   .bus_wr_stb(bus_wr_stb),
   .bus_rd_stb(bus_rd_stb),
   .bus_doe   (bus_doe),
   .addr_start(addr_start)
);

// File: tb/dma_bus_master_tb.sv
module dma_bus_master_tb;
   localparam int DW = 32;
   localparam int LW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [LW-1:0] cfg_burst_max = '0;
   logic [LW-1:0] rx_level = '0;
   logic [DW-1:0] rx_data = '0;
   logic          rx_pop;
   logic [LW-1:0] tx_space = '0;
   logic          tx_enable = 1'b0;
   logic          tx_push;
   logic [DW-1:0] tx_wdata;
   logic          bus_req;
   logic          bus_gnt = 1'b0;
   logic          bus_dir;
   logic          addr_start;
   logic          bus_wr_stb;
   logic          bus_rd_stb;
   logic [DW-1:0] bus_dout;
   logic          bus_doe;
   logic [DW-1:0] bus_din = '0;

   dma_bus_master #(.DATA_W(DW), .LVL_W(LW), .DEF_BURST(16)) u_dut (.*);

   always #5 clk = ~clk;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   int rx_cnt = 0, rx_head = 0, tx_sp = 0, cfg_v = 0;
   bit en_v = 0, prod_on = 0, drain_on = 0, arb_on = 0, pend_pop = 0, pend_push = 0;
   bit last_req = 0, last_gnt = 0, in_burst = 0, exp_rx = 0;
   int snap_rx = 0, snap_tx = 0, snap_cfg = 0;
   bit snap_en = 0;
   int exp_len = 0, burst_cnt = 0, resumed = 0;
   int blog_len[8];
   bit blog_rx[8];
   int bcount = 0;

   function automatic logic [DW-1:0] word_of(int i);
      return (DW'(i) * 32'h9E3779B1) ^ 32'h5A5A0000;
   endfunction

   function automatic int exp_burst(int lvl, int cfg);
      int lim = (cfg == 0) ? 16 : cfg;
      return (lvl < lim) ? lvl : lim;
   endfunction

   task automatic chk(bit ok, string rq, longint act, longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", rq, act, exp, $time);
      end
   endtask

   task automatic monitor();
      bit stb = bus_wr_stb || bus_rd_stb;
      if (stb) chk(bus_gnt && bus_req, "R3 strobe without grant/request", {bus_gnt, bus_req}, 3);
      chk(!(bus_doe && !bus_gnt), "R7 data enable without grant", bus_doe, 0);
      chk(!(bus_wr_stb && bus_rd_stb), "R10 both strobes", 1, 0);
      if (bus_req && !last_req) begin
         chk(snap_rx > 0 || (snap_en && snap_tx > 0), "R2/R6 request with nothing pending", 1, 0);
         exp_rx  = (snap_rx > 0);
         exp_len = exp_burst(exp_rx ? snap_rx : snap_tx, snap_cfg);
         burst_cnt = 0;
         in_burst  = 1;
      end
      if (in_burst && bus_req && burst_cnt == exp_len)
         chk(0, "R7 request held after last strobe", 1, 0);
      pend_pop  = 0;
      pend_push = 0;
      if (stb) begin
         chk(bus_wr_stb == exp_rx, "R5/R6 burst direction", bus_wr_stb, exp_rx);
         chk(bus_dir == exp_rx, "R5 bus_dir", bus_dir, exp_rx);
         chk(addr_start == (burst_cnt == 0), "R9 address start pulse", addr_start, burst_cnt == 0);
         if (bus_wr_stb) begin
            chk(bus_dout == word_of(rx_head), "R10 outbound data order", bus_dout, word_of(rx_head));
            chk(rx_pop && bus_doe && !tx_push, "R10 pop/enable on write", {rx_pop, bus_doe, tx_push}, 3'b110);
            pend_pop = 1;
         end else begin
            chk(tx_push && !rx_pop && !bus_doe, "R6 push on read", {tx_push, rx_pop, bus_doe}, 3'b100);
            chk(tx_wdata == bus_din, "R6 inbound data", tx_wdata, bus_din);
            pend_push = 1;
         end
         burst_cnt++;
      end else begin
         chk(!rx_pop && !tx_push && !addr_start, "R9 idle side signals", {rx_pop, tx_push, addr_start}, 0);
      end
      if (in_burst && bus_req && last_gnt && !bus_gnt && burst_cnt > 0 && burst_cnt < exp_len)
         resumed++;
      if (!bus_req && last_req) begin
         chk(burst_cnt == exp_len, "R4/R8 burst length", burst_cnt, exp_len);
         if (exp_rx && bus_gnt) chk(bus_doe, "R7 enable held while granted", bus_doe, 1);
         if (bcount < 8) begin
            blog_len[bcount] = burst_cnt;
            blog_rx[bcount]  = exp_rx;
         end
         bcount++;
         in_burst = 0;
      end
      last_req = bus_req;
      last_gnt = bus_gnt;
      snap_rx  = rx_cnt;
      snap_tx  = tx_sp;
      snap_en  = en_v;
      snap_cfg = cfg_v;
   endtask

   task automatic step();
      @(negedge clk);
      if (pend_pop)  begin rx_head++; rx_cnt--; end
      if (pend_push) tx_sp--;
      if (prod_on && $urandom % 4 == 0 && rx_cnt < 200) rx_cnt++;
      if (drain_on && $urandom % 3 == 0 && tx_sp < 200) tx_sp++;
      if (arb_on) begin
         if (!bus_gnt) begin
            if (last_req && $urandom % 2 == 0) bus_gnt = 1'b1;
         end else if (last_req) begin
            if ($urandom % 8 == 0) bus_gnt = 1'b0;
         end else if ($urandom % 2 == 0) begin
            bus_gnt = 1'b0;
         end
      end
      rx_level      = LW'(rx_cnt);
      rx_data       = word_of(rx_head);
      tx_space      = LW'(tx_sp);
      tx_enable     = en_v;
      cfg_burst_max = LW'(cfg_v);
      bus_din       = $urandom;
      #1;
      monitor();
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 4000; i++) begin
         if (rx_cnt == 0 && (!en_v || tx_sp == 0) && !bus_req && !bus_gnt && !in_burst) break;
         step();
      end
      step();
      step();
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      #1;
      chk({bus_req, bus_wr_stb, bus_rd_stb, bus_doe, addr_start, rx_pop, tx_push} == 0,
          "R1 outputs during reset", {bus_req, bus_wr_stb, bus_rd_stb, bus_doe, addr_start}, 0);
      @(negedge clk);
      rst_n = 1'b1;
      step();
      chk(!bus_req && !bus_doe, "R1 outputs after reset", {bus_req, bus_doe}, 0);

      // R6: inbound room but moves inhibited
      tx_sp = 5; en_v = 0;
      for (int i = 0; i < 6; i++) step();
      chk(!bus_req, "R6 no request while inbound disabled", bus_req, 0);
      tx_sp = 0;
      step();

      // R2: request one edge after level appears, arbiter silent
      rx_cnt = 3;
      step();
      chk(!bus_req, "R2 request not before edge", bus_req, 0);
      step();
      chk(bus_req, "R2 request after level seen", bus_req, 1);
      for (int i = 0; i < 3; i++) step();
      chk(bus_req && !bus_wr_stb, "R3 waits for grant", {bus_req, bus_wr_stb}, 2'b10);
      arb_on = 1;
      wait_idle();

      // R5: both pending, outbound first
      bcount = 0;
      rx_cnt = 2; tx_sp = 4; en_v = 1;
      wait_idle();
      chk(bcount == 2 && blog_rx[0] && blog_len[0] == 2, "R5 outbound burst first", blog_len[0], 2);
      chk(!blog_rx[1] && blog_len[1] == 4, "R6 inbound burst second", blog_len[1], 4);

      // R4: default limit of 16
      bcount = 0; en_v = 0; cfg_v = 0;
      rx_cnt = 40;
      wait_idle();
      chk(bcount == 3 && blog_len[0] == 16 && blog_len[1] == 16 && blog_len[2] == 8,
          "R4 default limit split", {blog_len[0][7:0], blog_len[1][7:0], blog_len[2][7:0]}, 24'h101008);

      // R4: programmed limit on inbound moves
      bcount = 0; cfg_v = 5; en_v = 1; tx_sp = 12;
      wait_idle();
      chk(bcount == 3 && blog_len[0] == 5 && blog_len[1] == 5 && blog_len[2] == 2,
          "R4 programmed limit split", {blog_len[0][7:0], blog_len[1][7:0], blog_len[2][7:0]}, 24'h050502);

      // random traffic
      prod_on = 1; drain_on = 1;
      for (int i = 0; i < 5000; i++) begin
         if (i % 250 == 0) begin
            case ($urandom % 6)
               0: cfg_v = 0; 1: cfg_v = 1; 2: cfg_v = 3;
               3: cfg_v = 7; 4: cfg_v = 16; default: cfg_v = 31;
            endcase
            en_v = ($urandom % 3 != 0);
         end
         step();
      end
      prod_on = 0; drain_on = 0; en_v = 0;
      wait_idle();
      chk(resumed > 0, "R8 paused bursts resumed", resumed, 1);
      chk(rx_cnt == 0 && !bus_req, "R2 all outbound words moved", rx_cnt, 0);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule